// File: doc/BRIEF.md
# Power-Down and Wake Sequencer

This block decides when the chip's clock sources may stop and in what order they come back. Software asks for the low-power state by writing 1 to bit 0 of the control register. The sequencer then drops the oscillator enable and the PLL enable, and it holds both low until a wake source shows up.

Three sources can end the sleep:
- the USB resume indication;
- a dedicated wake pin;
- a second wake pin that software may hand over to general-purpose I/O use.

All three are asynchronous levels and pass through a two-stage synchronizer.

On a wake, the oscillator enable returns first. A short start-up count then runs, after which the PLL enable returns. The PLL-lock indication to the core stays low until a settling counter expires. Only then does the CPU get a one-cycle wakeup interrupt. At the same moment the request bit clears itself, and a sticky status register records which sources caused the wake. Status bits are cleared by writing 1 to them. Wake handling does not depend on whether the USB bus is attached: the two pin sources work with the resume input idle.

If a wake level is already present when software makes the request, the block never stops the clocks. It raises the interrupt at once and records the source.

Top module: `pd_wake_seq`

## Requirements
- R1: After reset, osc_en, pll_en and pll_lock are 1 and wake_irq is 0. The control register (reg_sel=0) reads 3'b010: bit0 is the sleep request and bit1 enables the second wake pin. The status register (reg_sel=1) reads 0.
- R2: Writing 1 to control bit0 with no wake level present drives osc_en, pll_en and pll_lock to 0 one cycle after the write edge, and they stay 0 while no enabled wake level is present.
- R3: An enabled wake level asserted during sleep raises osc_en on the third clock edge after it is applied: two synchronizer stages plus one state update.
- R4: pll_en rises exactly OSC_CYCLES cycles after osc_en rises, and pll_en is never 1 while osc_en is 0.
- R5: wake_irq is a single-cycle pulse that comes exactly SETTLE_CYCLES cycles after pll_en rises. pll_lock stays 0 until that same cycle, and control bit0 reads 0 after the pulse.
- R6: Status bit0 records the USB resume input, bit1 the wake pin and bit2 the second wake pin. The bit of each source present when a wake is taken becomes 1.
- R7: Writing the status register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R8: With control bit1 at 0, the second wake pin neither ends sleep nor sets status bit2. The other sources still work.
- R9: If an enabled wake level is present when control bit0 is written to 1, osc_en never falls. wake_irq pulses on the cycle after the request is seen, and the source is recorded.
- R10: Writes to control bit0 are ignored outside the running state. A write of 0 during settling leaves the bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 wake status |
| reg_wdata | input | 3 | Write data |
| reg_rdata | output | 3 | Read data of the selected register |
| usb_resume | input | 1 | USB resume indication, asynchronous level |
| wake_pin | input | 1 | Dedicated wake pin, asynchronous level |
| wake2_pin | input | 1 | Second wake pin, shared with general I/O |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| pll_lock | output | 1 | PLL-lock indication to the core |
| wake_irq | output | 1 | One-cycle wakeup interrupt |

## Verification
The assertions assume the wake sources are levels that stay high until the sequence has moved on. They also assume that register writes come from a single master, so that a clear and a capture fall in distinct cycles except where priority defines the result. The bench changes wake inputs and write strobes on the falling edge only. It holds each wake level until the interrupt has been seen, and it releases all sources for at least three cycles before the next sleep request. This way a stale synchronized level can never turn a new request into an abort by accident.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_OSC_UP,
    ST_PLL_SETTLE,
    ST_WAKE
  } pd_state_t;

  localparam int SRC_N      = 3;
  localparam int SRC_RESUME = 0;
  localparam int SRC_PIN    = 1;
  localparam int SRC_PIN2   = 2;

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_STAT = 1'b1;

  // last counter value of an interval of n cycles
  function automatic int unsigned last_tick(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  // gate the second pin when it serves as general I/O
  function automatic logic [SRC_N-1:0] wake_mask(input logic [SRC_N-1:0] raw,
                                                 input logic pin2_en);
    logic [SRC_N-1:0] m;
    m = raw;
    m[SRC_PIN2] = raw[SRC_PIN2] & pin2_en;
    return m;
  endfunction

  // sticky bits: clear on write-one, set wins
  function automatic logic [SRC_N-1:0] sticky_next(input logic [SRC_N-1:0] cur,
                                                   input logic [SRC_N-1:0] clr,
                                                   input logic [SRC_N-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/pdw_sync.sv
module pdw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= '0;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/pdw_timer.sv
module pdw_timer
  import pdw_pkg::*;
#(
  parameter int unsigned OSC_CYCLES    = 4,
  parameter int unsigned SETTLE_CYCLES = 9600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic sel_settle,
  output logic done
);
  localparam int unsigned MAXC  = (OSC_CYCLES > SETTLE_CYCLES) ? OSC_CYCLES : SETTLE_CYCLES;
  localparam int          CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] OSC_LAST = CNT_W'(last_tick(OSC_CYCLES));
  localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(last_tick(SETTLE_CYCLES));

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = sel_settle ? SET_LAST : OSC_LAST;
  assign done = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
  end

  // R4: a running count never passes its interval
  a_r4_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= last));
endmodule

// File: rtl/pdw_fsm.sv
module pdw_fsm
  import pdw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req,
  input  logic [SRC_N-1:0] wake_vec,
  input  logic             tmr_done,
  output logic             tmr_clr,
  output logic             tmr_run,
  output logic             tmr_sel_settle,
  output logic             wake_take,
  output logic             in_run,
  output logic             seq_done,
  output logic             osc_en,
  output logic             pll_en,
  output logic             pll_lock,
  output logic             wake_irq
);
  pd_state_t state, nxt;
  logic      wake_any;

  assign wake_any = |wake_vec;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:        if (pd_req)   nxt = wake_any ? ST_WAKE : ST_SLEEP;
      ST_SLEEP:      if (wake_any) nxt = ST_OSC_UP;
      ST_OSC_UP:     if (tmr_done) nxt = ST_PLL_SETTLE;
      ST_PLL_SETTLE: if (tmr_done) nxt = ST_WAKE;
      ST_WAKE:                     nxt = ST_RUN;
      default:                     nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

  assign tmr_clr        = (nxt != state);
  assign tmr_run        = (state == ST_OSC_UP) || (state == ST_PLL_SETTLE);
  assign tmr_sel_settle = (state == ST_PLL_SETTLE);
  assign wake_take      = wake_any && (((state == ST_RUN) && pd_req) || (state == ST_SLEEP));
  assign in_run         = (state == ST_RUN);
  assign seq_done       = (state == ST_WAKE);

  assign osc_en   = (state != ST_SLEEP);
  assign pll_en   = (state != ST_SLEEP) && (state != ST_OSC_UP);
  assign pll_lock = (state == ST_RUN) || (state == ST_WAKE);
  assign wake_irq = (state == ST_WAKE);

  // R2: clocks stop only after a request
  a_r2_stop_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> $past(pd_req));
  // R3: oscillator restarts only on a wake level
  a_r3_restart_needs_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> $past(wake_any));
  // R4: PLL never runs without the oscillator
  a_r4_pll_after_osc: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |-> osc_en);
  // R5: interrupt is one cycle wide
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq);
  // R5: lock returns together with the interrupt
  a_r5_lock_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_lock) |-> wake_irq);
endmodule

// File: rtl/pdw_regs.sv
module pdw_regs
  import pdw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [SRC_N-1:0] reg_wdata,
  output logic [SRC_N-1:0] reg_rdata,
  input  logic             in_run,
  input  logic             seq_done,
  input  logic             wake_take,
  input  logic [SRC_N-1:0] wake_vec,
  output logic             ctrl_pd,
  output logic             ctrl_pin2_en
);
  logic [SRC_N-1:0] status;
  logic [SRC_N-1:0] clr_bits;
  logic [SRC_N-1:0] set_bits;
  logic             ctrl_wr;

  assign ctrl_wr  = reg_wr && (reg_sel == SEL_CTRL);
  assign clr_bits = (reg_wr && (reg_sel == SEL_STAT)) ? reg_wdata : '0;
  assign set_bits = wake_take ? wake_vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_pd      <= 1'b0;
      ctrl_pin2_en <= 1'b1;
    end else begin
      if (seq_done)             ctrl_pd <= 1'b0;
      else if (ctrl_wr && in_run) ctrl_pd <= reg_wdata[0];
      if (ctrl_wr)              ctrl_pin2_en <= reg_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= sticky_next(status, clr_bits, set_bits);
  end

  assign reg_rdata = (reg_sel == SEL_STAT) ? status
                                           : {{(SRC_N-2){1'b0}}, ctrl_pin2_en, ctrl_pd};

  // R6: every source present at a taken wake is recorded
  a_r6_take_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    wake_take |=> ((status & $past(wake_vec)) == $past(wake_vec)));
  // R10: request bit holds outside the running state
  a_r10_req_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_run && !seq_done) |=> (ctrl_pd == $past(ctrl_pd)));
  // R5: request bit clears once the sequence ends
  a_r5_req_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !ctrl_pd);
endmodule

// File: rtl/pd_wake_seq.sv
module pd_wake_seq
  import pdw_pkg::*;
#(
  parameter int unsigned OSC_CYCLES    = 4,
  parameter int unsigned SETTLE_CYCLES = 9600,
  parameter int          SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [SRC_N-1:0] reg_wdata,
  output logic [SRC_N-1:0] reg_rdata,
  input  logic             usb_resume,
  input  logic             wake_pin,
  input  logic             wake2_pin,
  output logic             osc_en,
  output logic             pll_en,
  output logic             pll_lock,
  output logic             wake_irq
);
  logic [SRC_N-1:0] raw_vec, sync_vec, wake_vec;
  logic ctrl_pd, ctrl_pin2_en;
  logic tmr_clr, tmr_run, tmr_sel_settle, tmr_done;
  logic wake_take, in_run, seq_done;

  always_comb begin
    raw_vec = '0;
    raw_vec[SRC_RESUME] = usb_resume;
    raw_vec[SRC_PIN]    = wake_pin;
    raw_vec[SRC_PIN2]   = wake2_pin;
  end

  pdw_sync #(.W(SRC_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_vec), .dout(sync_vec));

  assign wake_vec = wake_mask(sync_vec, ctrl_pin2_en);

  pdw_timer #(.OSC_CYCLES(OSC_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run),
    .sel_settle(tmr_sel_settle), .done(tmr_done));

  pdw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pd_req(ctrl_pd), .wake_vec(wake_vec),
    .tmr_done(tmr_done), .tmr_clr(tmr_clr), .tmr_run(tmr_run),
    .tmr_sel_settle(tmr_sel_settle), .wake_take(wake_take), .in_run(in_run),
    .seq_done(seq_done), .osc_en(osc_en), .pll_en(pll_en),
    .pll_lock(pll_lock), .wake_irq(wake_irq));

  pdw_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_run(in_run),
    .seq_done(seq_done), .wake_take(wake_take), .wake_vec(wake_vec),
    .ctrl_pd(ctrl_pd), .ctrl_pin2_en(ctrl_pin2_en));

  // R8: a disabled second pin never ends sleep alone
  a_r8_pin2_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(osc_en) && !ctrl_pin2_en) |-> $past(sync_vec[SRC_RESUME] | sync_vec[SRC_PIN]));
endmodule

// File: tb/pd_wake_seq_bench.sv
`timescale 1ns/1ps
module pd_wake_seq_bench;
  localparam int OSC_N = 4;
  localparam int SET_N = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [2:0] reg_wdata = '0;
  logic [2:0] reg_rdata;
  logic usb_resume = 1'b0, wake_pin = 1'b0, wake2_pin = 1'b0;
  logic osc_en, pll_en, pll_lock, wake_irq;

  int tests = 0, fails = 0;
  bit finished = 1'b0;
  logic [2:0] exp_stat = '0;

  always #2 clk = ~clk;

  pd_wake_seq #(.OSC_CYCLES(OSC_N), .SETTLE_CYCLES(SET_N)) u_pd_wake_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .usb_resume(usb_resume),
    .wake_pin(wake_pin), .wake2_pin(wake2_pin), .osc_en(osc_en),
    .pll_en(pll_en), .pll_lock(pll_lock), .wake_irq(wake_irq));

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [2:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [2:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  task automatic drive_src(input int src, input logic v);
    case (src)
      0: usb_resume = v;
      1: wake_pin = v;
      default: wake2_pin = v;
    endcase
  endtask

  task automatic release_all();
    usb_resume = 1'b0; wake_pin = 1'b0; wake2_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [2:0] v;
    check("R1 osc_en", osc_en, 1);
    check("R1 pll_en", pll_en, 1);
    check("R1 pll_lock", pll_lock, 1);
    check("R1 wake_irq", wake_irq, 0);
    rd(1'b0, v); check("R1 ctrl", v, 3'b010);
    rd(1'b1, v); check("R1 status", v, 0);
  endtask

  // sleep, wake by one source, check full timing
  task automatic t_sleep_wake(input int src);
    logic [2:0] v;
    int n;
    wr(1'b0, 3'b011);
    check("R2 osc on until state update", osc_en, 1);
    @(negedge clk);
    check("R2 osc_en off", osc_en, 0);
    check("R2 pll_en off", pll_en, 0);
    check("R2 pll_lock off", pll_lock, 0);
    repeat (5) @(negedge clk);
    check("R2 still asleep", osc_en, 0);
    drive_src(src, 1'b1);
    @(negedge clk); @(negedge clk);
    check("R3 osc_en before sync done", osc_en, 0);
    @(negedge clk);
    check("R3 osc_en third edge", osc_en, 1);
    check("R4 pll_en still off", pll_en, 0);
    n = 0;
    while (!pll_en && n < 1000) begin
      @(negedge clk); n++;
      if (!osc_en) check("R4 osc dropped", osc_en, 1);
    end
    check("R4 osc to pll cycles", n, OSC_N);
    n = 0;
    while (!wake_irq && n < 1000) begin
      if (n == 2) begin reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 3'b010; end
      if (n == 3) reg_wr = 1'b0;
      if (n == 5) begin rd(1'b0, v); check("R10 request kept in settle", v[0], 1); end
      if (pll_lock) check("R5 lock early", pll_lock, 0);
      @(negedge clk); n++;
    end
    check("R5 pll to irq cycles", n, SET_N);
    check("R5 lock with irq", pll_lock, 1);
    @(negedge clk);
    check("R5 irq single cycle", wake_irq, 0);
    rd(1'b0, v); check("R5 request self-cleared", v, 3'b010);
    exp_stat[src] = 1'b1;
    rd(1'b1, v); check("R6 status source", v, exp_stat);
    release_all();
  endtask

  task automatic t_w1c();
    logic [2:0] v;
    rd(1'b1, v); check("R7 status before clear", v, exp_stat);
    wr(1'b1, 3'b000);
    rd(1'b1, v); check("R7 zero write keeps", v, exp_stat);
    wr(1'b1, 3'b001);
    exp_stat[0] = 1'b0;
    rd(1'b1, v); check("R7 clear bit0 only", v, exp_stat);
    wr(1'b1, 3'b110);
    exp_stat = '0;
    rd(1'b1, v); check("R7 clear rest", v, 0);
  endtask

  task automatic t_gpio_mode();
    logic [2:0] v;
    int n;
    wr(1'b0, 3'b001);
    @(negedge clk);
    check("R8 asleep", osc_en, 0);
    wake2_pin = 1'b1;
    repeat (12) @(negedge clk);
    check("R8 pin2 ignored", osc_en, 0);
    rd(1'b1, v); check("R8 status bit2 clear", v[2], 0);
    wake_pin = 1'b1;
    n = 0;
    while (!wake_irq && n < 1000) begin @(negedge clk); n++; end
    check("R8 other source wakes", wake_irq, 1);
    rd(1'b1, v); check("R8 status only pin", v, 3'b010);
    release_all();
    wr(1'b1, 3'b111);
    wr(1'b0, 3'b010);
    rd(1'b0, v); check("R8 pin2 re-enabled", v, 3'b010);
  endtask

  task automatic t_abort();
    logic [2:0] v;
    usb_resume = 1'b1;
    repeat (3) @(negedge clk);
    wr(1'b0, 3'b011);
    check("R9 osc kept", osc_en, 1);
    @(negedge clk);
    check("R9 irq at once", wake_irq, 1);
    check("R9 osc never off", osc_en, 1);
    @(negedge clk);
    check("R9 irq ends", wake_irq, 0);
    rd(1'b0, v); check("R9 request cleared", v, 3'b010);
    rd(1'b1, v); check("R9 resume recorded", v, 3'b001);
    release_all();
    wr(1'b1, 3'b111);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_sleep_wake(0);
    t_sleep_wake(1);
    t_w1c();
    t_sleep_wake(2);
    wr(1'b1, 3'b100);
    exp_stat = '0;
    t_gpio_mode();
    t_abort();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog R1..: got %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule